// File: doc/BRIEF.md
# Dual-Link Pixel Router

This block is the parallel front end of a two-link flat-panel serializer. It takes one or two pixel ports, each carrying red, green and blue at `CW` bits per colour, plus data-enable, horizontal and vertical sync and two control bits for each link. It captures them on a selectable clock edge and places pixels onto two output links. A two-bit topology code chooses dual or single input against dual or single output. A shared option bit means something different in each topology. All output words leave on one internal clock, so later serializer stages see a single timing domain.

In dual-in/dual-out topology the links can carry a 23-stage pseudo-random test sequence in place of pixel data. A power-down input drops the output-enable flag and both link enables. Serialization, swing control and clock synthesis are outside this block.

Top module: `pixlink_router`

## Requirements
- R1: While `rst_n` is low, every output is 0, including `oe`, `l1_en` and `l2_en`.
- R2: With `link_mode`=2'b00 (two ports in, two links out) and `prbs_req` low, a sample captured for a clock cycle appears on the next rising edge: `l1_pix`=`px1` with `ctl_a`, `l2_pix`=`px2` with `ctl_b`. Both links carry the sample's `de`, `hsync` and `vsync`, and `l2_en` is 1.
- R3: With `rise_edge` high, inputs are taken at the rising edge. With `rise_edge` low, they are taken at the preceding falling edge. Output latency is one rising edge either way, and a change after the falling edge is not seen in falling mode.
- R4: With `link_mode`=2'b11 (one in, one out), link 1 carries `px1` with `ctl_a`. If `mode_opt` is 1, link 2 is an exact copy of link 1 and `l2_en` is 1. If `mode_opt` is 0, link 2 pixel and sideband are 0 and `l2_en` is 0.
- R5: With `link_mode`=2'b10 (one in, two out) and `mode_opt`=0, a cycle with `de` low outputs that sample on both links. During `de` high, pixels pair up starting with the first one after `de` rises. On the edge after the second pixel of a pair, link 1 gets the first pixel with its `ctl_a` and link 2 gets the second with its `ctl_b`. On the edge after the first pixel, the outputs hold.
- R6: With `link_mode`=2'b10 and `mode_opt`=1, `px1` is taken at both edges whatever `rise_edge` is. The falling-edge sample goes to link 1 and the following rising-edge sample goes to link 2, one pair per clock.
- R7: With `link_mode`=2'b01 (two in, one out), each pair is presented for two cycles while `de` is high. Link 1 emits `px1` with `ctl_a` and then `px2` with `ctl_b`. Link 2 is 0 and `l2_en` is 0.
- R8: With `link_mode`=2'b00 and `prbs_req` high, both pixel words carry the test word while sideband still passes through. The generator is a 23-bit register seeded with `SEED` (default all ones). Each step shifts left and loads bit 22 XOR bit 17 into bit 0. A word is 30 successive bit-22 values, placed most significant bit first, and each use advances the register by 30 steps.
- R9: In any other topology `prbs_req` is ignored: pixels pass as in R4..R7 and the generator does not advance, so the sequence resumes where it stopped.
- R10: With `pdn_n` low, `oe`, `l1_en` and `l2_en` are 0 from the next rising edge. They return to 1 (and `l2_en` to its topology value) one edge after `pdn_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rise_edge | input | 1 | 1 = capture on rising edge, 0 = falling edge |
| pdn_n | input | 1 | Active-low power-down |
| link_mode | input | 2 | Topology code (00, 10, 01, 11) |
| mode_opt | input | 1 | Distribution enable (11) or double-edge enable (10) |
| prbs_req | input | 1 | Test pattern request, effective only in 00 |
| px1 | input | 3*CW | First pixel of a pair, {R,G,B} |
| px2 | input | 3*CW | Second pixel of a pair, {R,G,B} |
| de | input | 1 | Data enable |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| ctl_a | input | CTW | Control bits for link 1 |
| ctl_b | input | CTW | Control bits for link 2 |
| oe | output | 1 | Output enable (0 models high impedance) |
| l1_en | output | 1 | Link 1 active |
| l1_pix | output | 3*CW | Link 1 pixel word |
| l1_de | output | 1 | Link 1 data enable |
| l1_hs | output | 1 | Link 1 horizontal sync |
| l1_vs | output | 1 | Link 1 vertical sync |
| l1_ctl | output | CTW | Link 1 control bits |
| l2_en | output | 1 | Link 2 active |
| l2_pix | output | 3*CW | Link 2 pixel word |
| l2_de | output | 1 | Link 2 data enable |
| l2_hs | output | 1 | Link 2 horizontal sync |
| l2_vs | output | 1 | Link 2 vertical sync |
| l2_ctl | output | CTW | Link 2 control bits |

## Verification
The assertions assume the topology code and option bit stay constant across a line. They also assume active lines in the one-in/two-out mode have an even pixel count, and that in the two-in/one-out mode each pair is held for two cycles. The stimulus changes topology only during a blanking cycle with `de` low, drives lines of whole pairs, and repeats each pair for exactly two cycles. Inputs change one nanosecond after the rising edge. In double-edge or falling-capture tests they also change one nanosecond after the falling edge, so each capture edge sees one settled value.

// File: rtl/pixlink_pkg.sv
`timescale 1ns/1ps
package pixlink_pkg;
   typedef enum logic [1:0] {
      LM_DD = 2'b00,
      LM_DS = 2'b01,
      LM_SD = 2'b10,
      LM_SS = 2'b11
   } link_mode_e;

   localparam int SYW      = 3;
   localparam int LFSR_W   = 23;
   localparam int LFSR_TAP = 17;
endpackage

// File: rtl/pixlink_capture.sv
`timescale 1ns/1ps
module pixlink_capture #(
   parameter  int PW      = 30,
   parameter  int CTW     = 2,
   parameter  bit DDR_CAP = 1'b1,
   localparam int BW      = 2*PW + pixlink_pkg::SYW + 2*CTW,
   localparam int DW      = PW + pixlink_pkg::SYW + CTW
) (
   input  logic          clk,
   input  logic          rise,
   input  logic [BW-1:0] din,
   output logic [BW-1:0] sel,
   output logic [DW-1:0] ddr_a,
   output logic [DW-1:0] ddr_b
);
   logic [BW-1:0] fcap;

   generate
      if (DDR_CAP) begin : g_fall
         always_ff @(negedge clk) fcap <= din;
      end else begin : g_nofall
         assign fcap = din;
      end
   endgenerate

   logic [PW-1:0]              f_p1, f_p2, r_p1, r_p2;
   logic [pixlink_pkg::SYW-1:0] f_sy, r_sy;
   logic [CTW-1:0]             f_c1, f_c2, r_c1, r_c2;
   assign {f_p1, f_p2, f_sy, f_c1, f_c2} = fcap;
   assign {r_p1, r_p2, r_sy, r_c1, r_c2} = din;

   assign sel   = rise ? din : fcap;
   assign ddr_a = {f_p1, f_sy, f_c1};
   assign ddr_b = {r_p1, r_sy, r_c2};
endmodule

// File: rtl/pixlink_prbs.sv
`timescale 1ns/1ps
module pixlink_prbs #(
   parameter int                            PW   = 30,
   parameter logic [pixlink_pkg::LFSR_W-1:0] SEED = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [PW-1:0] word
);
   import pixlink_pkg::*;
   logic [LFSR_W-1:0] st, st_nx;

   always_comb begin
      logic [LFSR_W-1:0] s;
      s    = st;
      word = '0;
      for (int i = 0; i < PW; i++) begin
         word[PW-1-i] = s[LFSR_W-1];
         s = {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
      end
      st_nx = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= SEED;
      else if (adv) st <= st_nx;
   end

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(st));
   a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      st != '0);
endmodule

// File: rtl/pixlink_route.sv
`timescale 1ns/1ps
module pixlink_route #(
   parameter  int PW  = 30,
   parameter  int CTW = 2,
   localparam int SBW = pixlink_pkg::SYW + CTW,
   localparam int BW  = 2*PW + pixlink_pkg::SYW + 2*CTW,
   localparam int DW  = PW + SBW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     mode,
   input  logic           opt,
   input  logic           prbs_req,
   input  logic           pdn_n,
   input  logic [BW-1:0]  w,
   input  logic [DW-1:0]  ddr_a,
   input  logic [DW-1:0]  ddr_b,
   input  logic [PW-1:0]  prbs_word,
   output logic           prbs_adv,
   output logic           oe,
   output logic           l1_en,
   output logic           l2_en,
   output logic [PW-1:0]  l1_pix,
   output logic [SBW-1:0] l1_sb,
   output logic [PW-1:0]  l2_pix,
   output logic [SBW-1:0] l2_sb
);
   import pixlink_pkg::*;

   link_mode_e lm;
   assign lm = link_mode_e'(mode);

   logic [PW-1:0]  w_p1, w_p2, h_p1, h_p2;
   logic [SYW-1:0] w_sy, h_sy;
   logic [CTW-1:0] w_c1, w_c2, h_c1, h_c2;
   logic [BW-1:0]  hold;
   logic           ph, w_de, dual_out, prbs_on;

   assign {w_p1, w_p2, w_sy, w_c1, w_c2} = w;
   assign {h_p1, h_p2, h_sy, h_c1, h_c2} = hold;
   assign w_de     = w_sy[SYW-1];
   assign prbs_on  = prbs_req && (lm == LM_DD);
   assign prbs_adv = prbs_on;
   assign dual_out = (lm == LM_DD) || (lm == LM_SD) || ((lm == LM_SS) && opt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe <= 1'b0;  l1_en <= 1'b0;  l2_en <= 1'b0;
         l1_pix <= '0; l1_sb <= '0; l2_pix <= '0; l2_sb <= '0;
         hold <= '0;  ph <= 1'b0;
      end else begin
         oe    <= pdn_n;
         l1_en <= pdn_n;
         l2_en <= pdn_n & dual_out;
         case (lm)
            LM_DD: begin
               ph     <= 1'b0;
               l1_pix <= prbs_on ? prbs_word : w_p1;
               l2_pix <= prbs_on ? prbs_word : w_p2;
               l1_sb  <= {w_sy, w_c1};
               l2_sb  <= {w_sy, w_c2};
            end
            LM_SS: begin
               ph     <= 1'b0;
               l1_pix <= w_p1;
               l1_sb  <= {w_sy, w_c1};
               l2_pix <= opt ? w_p1 : '0;
               l2_sb  <= opt ? {w_sy, w_c1} : '0;
            end
            LM_SD: begin
               if (opt) begin
                  ph <= 1'b0;
                  {l1_pix, l1_sb} <= ddr_a;
                  {l2_pix, l2_sb} <= ddr_b;
               end else if (!w_de) begin
                  ph     <= 1'b0;
                  l1_pix <= w_p1;  l1_sb <= {w_sy, w_c1};
                  l2_pix <= w_p1;  l2_sb <= {w_sy, w_c2};
               end else if (!ph) begin
                  ph   <= 1'b1;
                  hold <= w;
               end else begin
                  ph     <= 1'b0;
                  l1_pix <= h_p1;  l1_sb <= {h_sy, h_c1};
                  l2_pix <= w_p1;  l2_sb <= {w_sy, w_c2};
               end
            end
            default: begin
               l2_pix <= '0;
               l2_sb  <= '0;
               if (!w_de || !ph) begin
                  ph     <= w_de;
                  hold   <= w;
                  l1_pix <= w_p1;  l1_sb <= {w_sy, w_c1};
               end else begin
                  ph     <= 1'b0;
                  l1_pix <= h_p2;  l1_sb <= {h_sy, h_c2};
               end
            end
         endcase
      end
   end

   a_r2_dual_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (lm == LM_DD && !prbs_req) |=> (l1_pix == $past(w_p1) && l2_pix == $past(w_p2)));
   a_r4_copy_link: assert property (@(posedge clk) disable iff (!rst_n)
      (lm == LM_SS && opt) |=> (l2_pix == l1_pix && l2_sb == l1_sb && l2_en == l1_en));
   a_r7_link2_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lm == LM_DS) |=> (!l2_en && l2_pix == '0 && l2_sb == '0));
   a_r5_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lm == LM_SD && !opt && !w_de) |=> !ph);
   a_r10_power_down: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_n |=> (!oe && !l1_en && !l2_en));
endmodule

// File: rtl/pixlink_router.sv
`timescale 1ns/1ps
module pixlink_router #(
   parameter  int                            CW      = 10,
   parameter  int                            CTW     = 2,
   parameter  bit                            DDR_CAP = 1'b1,
   parameter  logic [pixlink_pkg::LFSR_W-1:0] SEED    = '1,
   localparam int                            PW      = 3*CW,
   localparam int                            SBW     = pixlink_pkg::SYW + CTW,
   localparam int                            BW      = 2*PW + pixlink_pkg::SYW + 2*CTW,
   localparam int                            DW      = PW + SBW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rise_edge,
   input  logic           pdn_n,
   input  logic [1:0]     link_mode,
   input  logic           mode_opt,
   input  logic           prbs_req,
   input  logic [PW-1:0]  px1,
   input  logic [PW-1:0]  px2,
   input  logic           de,
   input  logic           hsync,
   input  logic           vsync,
   input  logic [CTW-1:0] ctl_a,
   input  logic [CTW-1:0] ctl_b,
   output logic           oe,
   output logic           l1_en,
   output logic [PW-1:0]  l1_pix,
   output logic           l1_de,
   output logic           l1_hs,
   output logic           l1_vs,
   output logic [CTW-1:0] l1_ctl,
   output logic           l2_en,
   output logic [PW-1:0]  l2_pix,
   output logic           l2_de,
   output logic           l2_hs,
   output logic           l2_vs,
   output logic [CTW-1:0] l2_ctl
);
   if (CW < 1)     begin : g_bad_cw   $error("CW must be at least 1");   end
   if (CTW < 1)    begin : g_bad_ctw  $error("CTW must be at least 1");  end
   if (SEED == '0) begin : g_bad_seed $error("SEED must be nonzero");    end

   logic [BW-1:0]  w;
   logic [DW-1:0]  ddr_a, ddr_b;
   logic [PW-1:0]  prbs_word;
   logic           prbs_adv;
   logic [SBW-1:0] l1_sb, l2_sb;

   pixlink_capture #(.PW(PW), .CTW(CTW), .DDR_CAP(DDR_CAP)) u_cap (
      .clk   (clk),
      .rise  (rise_edge),
      .din   ({px1, px2, de, hsync, vsync, ctl_a, ctl_b}),
      .sel   (w),
      .ddr_a (ddr_a),
      .ddr_b (ddr_b)
   );

   pixlink_prbs #(.PW(PW), .SEED(SEED)) u_prbs (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (prbs_adv),
      .word  (prbs_word)
   );

   pixlink_route #(.PW(PW), .CTW(CTW)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (link_mode),
      .opt       (mode_opt),
      .prbs_req  (prbs_req),
      .pdn_n     (pdn_n),
      .w         (w),
      .ddr_a     (ddr_a),
      .ddr_b     (ddr_b),
      .prbs_word (prbs_word),
      .prbs_adv  (prbs_adv),
      .oe        (oe),
      .l1_en     (l1_en),
      .l2_en     (l2_en),
      .l1_pix    (l1_pix),
      .l1_sb     (l1_sb),
      .l2_pix    (l2_pix),
      .l2_sb     (l2_sb)
   );

   assign {l1_de, l1_hs, l1_vs, l1_ctl} = l1_sb;
   assign {l2_de, l2_hs, l2_vs, l2_ctl} = l2_sb;
endmodule

// File: tb/sim_pixlink_router.sv
`timescale 1ns/1ps
module sim_pixlink_router;
   localparam logic [22:0] SEED = 23'h7FFFFF;

   logic        clk = 1'b0, rst_n = 1'b0, rise_edge = 1'b1, pdn_n = 1'b1;
   logic [1:0]  link_mode = 2'b00;
   logic        mode_opt = 1'b0, prbs_req = 1'b0;
   logic [29:0] px1 = '0, px2 = '0;
   logic        de = 1'b0, hsync = 1'b0, vsync = 1'b0;
   logic [1:0]  ctl_a = '0, ctl_b = '0;
   logic        oe, l1_en, l1_de, l1_hs, l1_vs, l2_en, l2_de, l2_hs, l2_vs;
   logic [29:0] l1_pix, l2_pix;
   logic [1:0]  l1_ctl, l2_ctl;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   logic [22:0] pst;

   pixlink_router u0 (.*);

   always #2.5 clk = ~clk;

   function automatic logic [29:0] pa(int i); return 30'(i * 7919 + 13);       endfunction
   function automatic logic [29:0] pb(int i); return 30'(i * 104729 + 977);    endfunction
   function automatic logic hsf(int i);       return i[0];                      endfunction
   function automatic logic vsf(int i);       return i[1];                      endfunction
   function automatic logic [1:0] caf(int i); return 2'(i >> 2);                endfunction
   function automatic logic [1:0] cbf(int i); return 2'(i * 3);                 endfunction
   function automatic logic [4:0] sba(int i, logic d); return {d, hsf(i), vsf(i), caf(i)}; endfunction
   function automatic logic [4:0] sbb(int i, logic d); return {d, hsf(i), vsf(i), cbf(i)}; endfunction

   function automatic logic [29:0] pword(logic [22:0] s);
      logic [29:0] r;
      for (int k = 0; k < 30; k++) begin
         r[29-k] = s[22];
         s = {s[21:0], s[22] ^ s[17]};
      end
      return r;
   endfunction
   function automatic logic [22:0] pnext(logic [22:0] s);
      for (int k = 0; k < 30; k++) s = {s[21:0], s[22] ^ s[17]};
      return s;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(int i, logic d);
      px1 = pa(i); px2 = pb(i); de = d;
      hsync = hsf(i); vsync = vsf(i); ctl_a = caf(i); ctl_b = cbf(i);
   endtask

   task automatic tick;
      @(posedge clk); #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [29:0] e1, e2;
      logic [4:0]  s1, s2;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 l1_pix", 64'(l1_pix), 0);
      chk("R1 l2_pix", 64'(l2_pix), 0);
      chk("R1 enables", 64'({oe, l1_en, l2_en}), 0);
      chk("R1 sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl, l2_de, l2_ctl}), 0);
      rst_n = 1'b1;

      // R2 dual in / dual out, rising capture
      for (int i = 0; i < 32; i++) begin
         drive(i, i[2]);
         tick();
         chk("R2 l1_pix", 64'(l1_pix), 64'(pa(i)));
         chk("R2 l2_pix", 64'(l2_pix), 64'(pb(i)));
         chk("R2 l1 sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(sba(i, i[2])));
         chk("R2 l2 sideband", 64'({l2_de, l2_hs, l2_vs, l2_ctl}), 64'(sbb(i, i[2])));
         chk("R2 enables", 64'({oe, l1_en, l2_en}), 64'(3'b111));
      end

      // R3 falling capture sweep
      rise_edge = 1'b0;
      for (int i = 32; i < 48; i++) begin
         drive(i, 1'b1);
         tick();
         chk("R3 falling l1", 64'(l1_pix), 64'(pa(i)));
         chk("R3 falling l2", 64'(l2_pix), 64'(pb(i)));
      end
      // R3 late change after falling edge is not seen in falling mode
      drive(100, 1'b1); #2.5; drive(101, 1'b1); tick();
      chk("R3 falling ignores late", 64'(l1_pix), 64'(pa(100)));
      rise_edge = 1'b1;
      drive(102, 1'b1); #2.5; drive(103, 1'b1); tick();
      chk("R3 rising takes late", 64'(l1_pix), 64'(pa(103)));

      // R4 single/single, no distribution then distribution
      link_mode = 2'b11;
      for (int i = 120; i < 136; i++) begin
         mode_opt = i[3];
         drive(i, 1'b1);
         tick();
         chk("R4 l1_pix", 64'(l1_pix), 64'(pa(i)));
         chk("R4 l1 sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(sba(i, 1'b1)));
         chk("R4 l2_pix", 64'(l2_pix), i[3] ? 64'(pa(i)) : 64'(0));
         chk("R4 l2 sideband", 64'({l2_de, l2_hs, l2_vs, l2_ctl}), i[3] ? 64'(sba(i, 1'b1)) : 64'(0));
         chk("R4 l2_en", 64'(l2_en), 64'(i[3]));
      end

      // R5 single in / dual out, alternating
      link_mode = 2'b10; mode_opt = 1'b0; de = 1'b0;
      drive(200, 1'b0); tick();
      chk("R5 blank l1", 64'(l1_pix), 64'(pa(200)));
      chk("R5 blank l2", 64'(l2_pix), 64'(pa(200)));
      chk("R5 blank l2 sideband", 64'({l2_de, l2_hs, l2_vs, l2_ctl}), 64'(sbb(200, 1'b0)));
      e1 = pa(200); e2 = pa(200);
      for (int k = 0; k < 8; k++) begin
         drive(210 + 2*k, 1'b1); tick();
         chk("R5 hold l1", 64'(l1_pix), 64'(e1));
         chk("R5 hold l2", 64'(l2_pix), 64'(e2));
         drive(211 + 2*k, 1'b1); tick();
         e1 = pa(210 + 2*k); e2 = pa(211 + 2*k);
         chk("R5 pair l1", 64'(l1_pix), 64'(e1));
         chk("R5 pair l2", 64'(l2_pix), 64'(e2));
         chk("R5 l1 sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(sba(210 + 2*k, 1'b1)));
         chk("R5 l2 sideband", 64'({l2_de, l2_hs, l2_vs, l2_ctl}), 64'(sbb(211 + 2*k, 1'b1)));
      end
      drive(230, 1'b0); tick();
      chk("R5 end blank", 64'({l1_de, l2_de}), 0);

      // R6 double-edge input, both rise_edge settings
      mode_opt = 1'b1;
      for (int k = 0; k < 12; k++) begin
         rise_edge = (k < 6);
         drive(300 + 2*k, 1'b1); #2.5; drive(301 + 2*k, 1'b1); tick();
         chk("R6 l1 falling sample", 64'(l1_pix), 64'(pa(300 + 2*k)));
         chk("R6 l2 rising sample", 64'(l2_pix), 64'(pa(301 + 2*k)));
         s1 = sba(300 + 2*k, 1'b1); s2 = sbb(301 + 2*k, 1'b1);
         chk("R6 l1 sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(s1));
         chk("R6 l2 sideband", 64'({l2_de, l2_hs, l2_vs, l2_ctl}), 64'(s2));
      end
      rise_edge = 1'b1; mode_opt = 1'b0;
      drive(399, 1'b0); tick();

      // R7 dual in / single out
      link_mode = 2'b01;
      drive(400, 1'b0); tick();
      chk("R7 blank l1", 64'(l1_pix), 64'(pa(400)));
      for (int k = 0; k < 10; k++) begin
         drive(410 + k, 1'b1); tick();
         chk("R7 first l1", 64'(l1_pix), 64'(pa(410 + k)));
         chk("R7 first sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(sba(410 + k, 1'b1)));
         tick();
         chk("R7 second l1", 64'(l1_pix), 64'(pb(410 + k)));
         chk("R7 second sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(sbb(410 + k, 1'b1)));
         chk("R7 link2 off", 64'({l2_en, l2_pix, l2_de, l2_ctl}), 0);
      end
      drive(430, 1'b0); tick();

      // R8 test pattern in dual/dual
      link_mode = 2'b00; prbs_req = 1'b1; pst = SEED;
      for (int j = 0; j < 10; j++) begin
         drive(500 + j, 1'b1); tick();
         chk("R8 l1 pattern", 64'(l1_pix), 64'(pword(pst)));
         chk("R8 l2 pattern", 64'(l2_pix), 64'(pword(pst)));
         chk("R8 sideband", 64'({l1_de, l1_hs, l1_vs, l1_ctl}), 64'(sba(500 + j, 1'b1)));
         pst = pnext(pst);
      end

      // R9 request ignored outside dual/dual; sequence resumes
      link_mode = 2'b11; mode_opt = 1'b0;
      for (int j = 0; j < 6; j++) begin
         drive(600 + j, 1'b1); tick();
         chk("R9 pixels pass", 64'(l1_pix), 64'(pa(600 + j)));
      end
      link_mode = 2'b00;
      for (int j = 0; j < 3; j++) begin
         drive(620 + j, 1'b1); tick();
         chk("R9 sequence resumes", 64'(l1_pix), 64'(pword(pst)));
         pst = pnext(pst);
      end
      prbs_req = 1'b0;

      // R10 power-down
      pdn_n = 1'b0; drive(700, 1'b1); tick();
      chk("R10 powered down", 64'({oe, l1_en, l2_en}), 0);
      tick();
      chk("R10 stays down", 64'({oe, l1_en, l2_en}), 0);
      pdn_n = 1'b1; tick();
      chk("R10 restored", 64'({oe, l1_en, l2_en}), 64'(3'b111));

      finish_run();
   end
endmodule